// File: doc/BRIEF.md
# Two-Wire Bus Master Controller

This block is a master for a two-wire serial bus with an open-drain clock line and an open-drain data line. It never drives a line high. It pulls a line low through an output enable and reads both lines back through two-flop synchronizers. Software programs it through a byte-wide register file with combinational read data and single-cycle write strobes. Writing the command register starts one bus operation, which can be one of these:
- a START (or repeated START) followed by the address byte;
- a data byte sent out;
- a data byte read in;
- a STOP only.

A flag in the command byte appends a STOP to any byte operation.

The outgoing 7-bit address comes from one of two address registers, chosen by a control bit. The controller can be set to hold off a START while another master owns the bus. It can also be set to give up the bus when the level it reads back differs from a bit it is sending. Four sticky flags report progress: operation done, arbitration lost, byte received and byte sent. Software clears a flag by writing 1 to it. The interrupt output is high while any flag is set. The register interface is plain control access, with no back-pressure. Commands that arrive while an operation is running are dropped.

Register offsets:

| Offset | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | address 1 |
| 3 | address 2 |
| 4 | data |
| 5 | command (write-only, reads 00h) |

Control register bits:

| Bit | Meaning |
|---|---|
| 7 | enable |
| 6 | master select |
| 5 | address-register select |
| 4 | arbitration check |
| 3 | bus-busy check |
| 2:0 | rate select |

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset the registers read as follows: control 04h, status 00h, address 1 A0h, address 2 60h, data 00h. Both output enables are 0 and irq is 0.
- R2: Command kind 01 (command bits 1:0) produces SDA falling while SCL is high. It then sends MSB first the 7 address bits from bits 7:1 of address 1 (control bit 5 = 0) or address 2 (bit 5 = 1), followed by command bit 2 as the R/W bit.
- R3: Command kind 10 sends the data register MSB first and releases SDA for a ninth clock. The level read back in that clock is latched into status bit 2 (1 = NACK). Status bit 4 (sent) and bit 7 (done) are set even on a NACK.
- R4: Command kind 11 releases SDA for 8 clocks and shifts the sampled bits into the data register, MSB first. In the ninth clock it drives command bit 3 as the acknowledge (0 = ACK, pulled low) and copies that bit into status bit 1. It sets status bit 5 (received) and bit 7.
- R5: Command bit 4 (alone, or with a byte kind) ends the operation with a STOP: SDA rises while SCL is high, after which both lines are released.
- R6: A kind-01 command issued while the controller still holds the bus produces a repeated START.
- R7: Status bit 0 is set by a START seen on the lines and cleared by a STOP. With control bit 3 set, a START is held off while bit 0 is 1. With bit 3 clear, the START is issued at once.
- R8: With control bit 4 set, a sent 1 read back as 0 sets status bit 6, releases both lines and returns to idle without setting bit 7. With bit 4 clear, the mismatch is ignored and the byte completes.
- R9: Writing 1 to status bits 7:4 clears those flags and writing 0 leaves them unchanged. irq is the OR of the four flags.
- R10: Each SCL half period lasts FAST_HALF << (7 - rate select) clock cycles.
- R11: A command is ignored when control bit 7 or bit 6 is 0, or while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |
| irq | output | 1 | OR of the status flags |

## Verification
The bench builds the controller with FAST_HALF = 3. The fastest rate select then gives a 3-cycle half period, and rate select 5 gives a 12-cycle half period. Whole address and data bytes therefore take a few dozen cycles, and the exact SCL period can be measured at two rates. A behavioural slave on the wired-AND lines acknowledges, sends read data and captures written bytes. A second pull-down imitates a competing master, which exercises the bus-busy hold-off and arbitration loss in both enable settings.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_AD1  = 3'd2;
  localparam logic [2:0] REG_AD2  = 3'd3;
  localparam logic [2:0] REG_DATA = 3'd4;
  localparam logic [2:0] REG_CMD  = 3'd5;

  localparam int CTL_EN   = 7;
  localparam int CTL_MST  = 6;
  localparam int CTL_ASEL = 5;
  localparam int CTL_ARB  = 4;
  localparam int CTL_BUSY = 3;

  localparam int CMD_RW   = 2;
  localparam int CMD_ACK  = 3;
  localparam int CMD_STOP = 4;

  localparam logic [1:0] K_NONE  = 2'b00;
  localparam logic [1:0] K_START = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;
  localparam logic [1:0] K_READ  = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_RS, ST_SA, ST_SB, ST_LO, ST_HI,
    ST_ALO, ST_AHI, ST_PLO, ST_PHI, ST_PEND
  } state_t;
endpackage

// File: rtl/i2cm_line_mon.sv
module i2cm_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic busy
);
  localparam int LINES = 2;
  logic [LINES-1:0] raw;
  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] prev_q;
  logic scl_now, sda_now, start_ev, stop_ev;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= '1;
      else if (g == 0) sync_q[g] <= raw;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  assign scl_now  = sync_q[SYNC_STAGES-1][1];
  assign sda_now  = sync_q[SYNC_STAGES-1][0];
  assign start_ev = scl_now & prev_q[1] & prev_q[0] & ~sda_now;
  assign stop_ev  = scl_now & prev_q[1] & ~prev_q[0] & sda_now;
  assign sda_s    = sda_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      busy   <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      if (start_ev) busy <= 1'b1;
      else if (stop_ev) busy <= 1'b0;
    end
  end

  p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy);
  p_busy_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !busy);
endmodule

// File: rtl/i2cm_rate_gen.sv
module i2cm_rate_gen #(
  parameter int FAST_HALF = 25,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int SEL_MAX = (1 << SEL_W) - 1;
  localparam int CNT_W   = $clog2(FAST_HALF + 1) + SEL_MAX;

  logic [CNT_W-1:0] half, cnt_q;

  assign half = CNT_W'(FAST_HALF) << (SEL_W'(SEL_MAX) - sel);
  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!run || cnt_q == '0) cnt_q <= half - 1'b1;
    else cnt_q <= cnt_q - 1'b1;
  end

  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl import i2cm_pkg::*; #(
  parameter int         FAST_HALF = 25,
  parameter logic [7:0] AD1_RST   = 8'hA0,
  parameter logic [7:0] AD2_RST   = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [7:0] ctrl_q, ad1_q, ad2_q, data_q, sh_q;
  logic [6:0] sel_addr;
  logic f_done, f_arb, f_rx, f_tx, rxak_q, txak_q;
  logic own_q, tx_q, stop_q, ack_q;
  logic [BIT_W-1:0] bit_q;
  state_t st_q;
  logic sda_s, busy, tick, run, master_on, cmd_wr, sta_wr;
  logic scl_drv, sda_drv;

  i2cm_line_mon #(.SYNC_STAGES(2)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .busy(busy));

  i2cm_rate_gen #(.FAST_HALF(FAST_HALF), .SEL_W(SEL_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(ctrl_q[SEL_W-1:0]), .tick(tick));

  assign master_on = ctrl_q[CTL_EN] & ctrl_q[CTL_MST];
  assign run       = (st_q != ST_IDLE) && (st_q != ST_WAIT);
  assign cmd_wr    = reg_wr && (reg_addr == REG_CMD) && master_on && (st_q == ST_IDLE);
  assign sta_wr    = reg_wr && (reg_addr == REG_STAT);
  assign sel_addr  = ctrl_q[CTL_ASEL] ? ad2_q[7:1] : ad1_q[7:1];
  assign irq       = f_done | f_arb | f_rx | f_tx;

  always_comb begin
    unique case (reg_addr)
      REG_CTRL: reg_rdata = ctrl_q;
      REG_STAT: reg_rdata = {f_done, f_arb, f_rx, f_tx, 1'b0, rxak_q, txak_q, busy};
      REG_AD1:  reg_rdata = ad1_q;
      REG_AD2:  reg_rdata = ad2_q;
      REG_DATA: reg_rdata = data_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  always_comb begin
    scl_drv = 1'b0;
    sda_drv = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_WAIT: scl_drv = own_q;
      ST_RS:  scl_drv = 1'b1;
      ST_SB:  sda_drv = 1'b1;
      ST_LO:  begin scl_drv = 1'b1; sda_drv = tx_q & ~sh_q[7]; end
      ST_HI:  sda_drv = tx_q & ~sh_q[7];
      ST_ALO: begin scl_drv = 1'b1; sda_drv = ~tx_q & ~ack_q; end
      ST_AHI: sda_drv = ~tx_q & ~ack_q;
      ST_PLO: begin scl_drv = 1'b1; sda_drv = 1'b1; end
      ST_PHI: sda_drv = 1'b1;
      default: ;
    endcase
  end

  assign scl_oe = master_on & scl_drv;
  assign sda_oe = master_on & sda_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h04; ad1_q <= AD1_RST; ad2_q <= AD2_RST; data_q <= 8'h00;
      f_done <= 1'b0; f_arb <= 1'b0; f_rx <= 1'b0; f_tx <= 1'b0;
      rxak_q <= 1'b0; txak_q <= 1'b0; own_q <= 1'b0; tx_q <= 1'b0;
      stop_q <= 1'b0; ack_q <= 1'b0; bit_q <= '0; sh_q <= '0; st_q <= ST_IDLE;
    end else begin
      if (reg_wr && reg_addr == REG_CTRL) ctrl_q <= reg_wdata;
      if (reg_wr && reg_addr == REG_AD1)  ad1_q  <= reg_wdata;
      if (reg_wr && reg_addr == REG_AD2)  ad2_q  <= reg_wdata;
      if (reg_wr && reg_addr == REG_DATA) data_q <= reg_wdata;
      if (sta_wr) begin
        f_done <= f_done & ~reg_wdata[7];
        f_arb  <= f_arb  & ~reg_wdata[6];
        f_rx   <= f_rx   & ~reg_wdata[5];
        f_tx   <= f_tx   & ~reg_wdata[4];
      end
      if (!master_on) begin
        st_q  <= ST_IDLE;
        own_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (cmd_wr) begin
            stop_q <= reg_wdata[CMD_STOP];
            ack_q  <= reg_wdata[CMD_ACK];
            bit_q  <= '0;
            unique case (reg_wdata[1:0])
              K_START: begin
                tx_q <= 1'b1;
                sh_q <= {sel_addr, reg_wdata[CMD_RW]};
                st_q <= own_q ? ST_RS : (ctrl_q[CTL_BUSY] && busy) ? ST_WAIT : ST_SA;
              end
              K_WRITE: if (own_q) begin tx_q <= 1'b1; sh_q <= data_q; st_q <= ST_LO; end
              K_READ:  if (own_q) begin tx_q <= 1'b0; st_q <= ST_LO; end
              default: if (own_q && reg_wdata[CMD_STOP]) st_q <= ST_PLO;
            endcase
          end
          ST_WAIT: if (!busy) st_q <= ST_SA;
          ST_RS:   if (tick) st_q <= ST_SA;
          ST_SA:   if (tick) st_q <= ST_SB;
          ST_SB:   if (tick) begin st_q <= ST_LO; own_q <= 1'b1; end
          ST_LO:   if (tick) st_q <= ST_HI;
          ST_HI:   if (tick) begin
            if (tx_q && ctrl_q[CTL_ARB] && sh_q[7] && !sda_s) begin
              f_arb <= 1'b1; own_q <= 1'b0; st_q <= ST_IDLE;
            end else begin
              sh_q  <= {sh_q[6:0], sda_s};
              bit_q <= bit_q + 1'b1;
              st_q  <= (bit_q == BIT_W'(BYTE_W-1)) ? ST_ALO : ST_LO;
            end
          end
          ST_ALO:  if (tick) st_q <= ST_AHI;
          ST_AHI:  if (tick) begin
            f_done <= 1'b1;
            if (tx_q) begin rxak_q <= sda_s; f_tx <= 1'b1; end
            else begin data_q <= sh_q; txak_q <= ack_q; f_rx <= 1'b1; end
            st_q <= stop_q ? ST_PLO : ST_IDLE;
          end
          ST_PLO:  if (tick) st_q <= ST_PHI;
          ST_PHI:  if (tick) st_q <= ST_PEND;
          ST_PEND: if (tick) begin st_q <= ST_IDLE; own_q <= 1'b0; f_done <= 1'b1; end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_wait_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> $past(busy));
  p_arb_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_arb) |-> (!scl_oe && !sda_oe));
  p_sda_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HI && $past(st_q) == ST_HI && master_on && $past(master_on)) |-> $stable(sda_oe));
  p_stop_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEND) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2cm_ctrl_bench.sv
module i2cm_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FAST_HALF  = 3;
  // {read, ack/nack, byte}
  localparam logic [9:0] VEC [4] = '{10'h05A, 10'h1C3, 10'h2A5, 10'h33C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0] ra = '0;
  logic       rw = 1'b0;
  logic [7:0] wd = '0;
  wire  [7:0] rd;
  wire scl_oe, sda_oe, irq;
  logic s_pull = 1'b0, x_pull = 1'b0;
  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | s_pull | x_pull);

  i2cm_ctrl #(.FAST_HALF(FAST_HALF)) u_i2cm_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(ra), .reg_wr(rw), .reg_wdata(wd),
    .reg_rdata(rd), .scl_in(scl_l), .sda_in(sda_l), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .irq(irq));

  logic s_txmode = 1'b0, s_nack = 1'b0, m_ack = 1'b0;
  logic [7:0] s_byte = '0, cap = '0;
  int bitcnt = 0, n_start = 0, n_stop = 0, cyc = 0, t_last = 0, t_prev = 0;
  logic pscl = 1'b1, psda = 1'b1, poe = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!scl_oe && poe) begin t_prev = t_last; t_last = cyc; end
    poe = scl_oe;
    if (pscl && scl_l && psda && !sda_l) begin n_start++; bitcnt = 0; s_pull = 1'b0; end
    else if (pscl && scl_l && !psda && sda_l) begin n_stop++; bitcnt = 0; end
    else if (!pscl && scl_l) begin
      if (bitcnt < 8) cap = {cap[6:0], sda_l}; else m_ack = sda_l;
      bitcnt++;
    end else if (pscl && !scl_l) begin
      if (bitcnt == 8) s_pull = s_txmode ? 1'b0 : !s_nack;
      else if (bitcnt == 9) begin bitcnt = 0; s_pull = 1'b0; end
      else if (s_txmode && bitcnt >= 1) s_pull = !s_byte[7-bitcnt];
    end
    pscl = scl_l;
    psda = sda_l;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); ra = a; wd = d; rw = 1'b1;
    @(negedge clk); rw = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); ra = a; #1 d = rd;
  endtask

  task automatic wait_only();
    for (int n = 0; n < 5000 && !irq; n++) @(negedge clk);
  endtask

  task automatic wait_irq(output logic [7:0] st);
    wait_only();
    rdr(3'd1, st);
    wr(3'd1, 8'hF0);
  endtask

  task automatic cmd(input logic [7:0] c, output logic [7:0] st);
    wr(3'd5, c);
    wait_irq(st);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v, st;
    int n0, t0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdr(3'd0, v); chk("R1 ctrl", v, 8'h04);
    rdr(3'd1, v); chk("R1 status", v, 8'h00);
    rdr(3'd2, v); chk("R1 addr1", v, 8'hA0);
    rdr(3'd3, v); chk("R1 addr2", v, 8'h60);
    rdr(3'd4, v); chk("R1 data", v, 8'h00);
    chk("R1 lines/irq", {scl_oe, sda_oe, irq}, 3'b000);

    // R11 ignored when slave selected or disabled
    wr(3'd0, 8'h87); wr(3'd5, 8'h01); repeat (60) @(negedge clk);
    chk("R11 slave mode", {scl_oe, irq, n_start[3:0]}, 6'h0);
    wr(3'd0, 8'h47); wr(3'd5, 8'h01); repeat (60) @(negedge clk);
    chk("R11 disabled", {scl_oe, irq, n_start[3:0]}, 6'h0);

    // R2 start + address from register 1
    wr(3'd0, 8'hC7);
    cmd(8'h01, st);
    chk("R2 start seen", n_start, 1);
    chk("R2 address byte", cap, 8'hA0);
    chk("R2 done/ack", {st[7], st[2]}, 2'b10);

    // vector table: R3 writes, R4 reads
    for (int i = 0; i < 4; i++) begin
      if (!VEC[i][9]) begin
        s_txmode = 1'b0; s_nack = VEC[i][8];
        wr(3'd4, VEC[i][7:0]);
        cmd(8'h02, st);
        chk("R3 byte on bus", cap, VEC[i][7:0]);
        chk("R3 rx ack bit", st[2], VEC[i][8]);
        chk("R3 sent/done flags", {st[7], st[4]}, 2'b11);
      end else begin
        s_txmode = 1'b1; s_byte = VEC[i][7:0]; s_pull = !VEC[i][7];
        cmd(8'h03 | {4'h0, VEC[i][8], 3'b000}, st);
        rdr(3'd4, v);
        chk("R4 data reg", v, VEC[i][7:0]);
        chk("R4 tx ack status", st[1], VEC[i][8]);
        chk("R4 ack on bus", m_ack, VEC[i][8]);
        chk("R4 recv/done flags", {st[7], st[5]}, 2'b11);
        s_txmode = 1'b0;
      end
    end
    s_nack = 1'b0;

    // R6 repeated start, address register 2, rw=1
    wr(3'd0, 8'hE7);
    n0 = n_start;
    cmd(8'h05, st);
    chk("R6 repeated start", n_start, n0 + 1);
    chk("R2 address 2 byte", cap, 8'h61);

    // R10 rate
    wr(3'd0, 8'hC5); wr(3'd4, 8'h96);
    cmd(8'h02, st);
    chk("R10 period sel5", t_last - t_prev, 24);
    wr(3'd0, 8'hC7);
    cmd(8'h02, st);
    chk("R10 period sel7", t_last - t_prev, 6);

    // R5 stop
    n0 = n_stop;
    cmd(8'h10, st);
    chk("R5 stop seen", n_stop, n0 + 1);
    chk("R5 lines released", {scl_oe, sda_oe, st[7]}, 3'b001);
    rdr(3'd1, v); chk("R7 busy cleared by stop", v[0], 1'b0);

    // R11 command during operation dropped
    cmd(8'h01, st);
    wr(3'd4, 8'h11); wr(3'd5, 8'h02); repeat (5) @(negedge clk);
    wr(3'd5, 8'h03);
    wait_irq(st);
    chk("R11 busy engine drops read", {st[5], st[4]}, 2'b01);
    cmd(8'h10, st);

    // R9 write-one-to-clear
    wr(3'd5, 8'h01); wait_only(); repeat (2) @(negedge clk);
    rdr(3'd1, v); chk("R9 flags set", v[7:4], 4'h9);
    wr(3'd1, 8'h80); rdr(3'd1, v);
    chk("R9 partial clear", {v[7:4], irq}, 5'b00011);
    wr(3'd1, 8'h10);
    chk("R9 irq low", irq, 1'b0);
    cmd(8'h10, st);

    // R7 busy check enabled
    x_pull = 1'b1; repeat (10) @(negedge clk);
    rdr(3'd1, v); chk("R7 busy seen", v[0], 1'b1);
    wr(3'd0, 8'hCF); wr(3'd5, 8'h01); repeat (60) @(negedge clk);
    chk("R7 start held off", {scl_oe, sda_oe, irq}, 3'b000);
    x_pull = 1'b0;
    wait_irq(st);
    chk("R7 start after free", st[7], 1'b1);
    cmd(8'h10, st);

    // R7 busy check disabled
    x_pull = 1'b1; repeat (10) @(negedge clk);
    wr(3'd0, 8'hC7); t0 = cyc; wr(3'd5, 8'h01);
    wait_irq(st);
    chk("R7 immediate start", {st[7], 1'b0 + ((cyc - t0) < 150)}, 2'b11);
    x_pull = 1'b0;
    cmd(8'h10, st);

    // R8 arbitration enabled
    wr(3'd0, 8'hD7); wr(3'd5, 8'h01); x_pull = 1'b1;
    wait_only();
    chk("R8 lost released", {scl_oe, sda_oe}, 2'b00);
    wait_irq(st);
    chk("R8 lost flag", {st[7], st[6]}, 2'b01);
    x_pull = 1'b0; repeat (10) @(negedge clk);

    // R8 arbitration disabled
    wr(3'd0, 8'hC7); wr(3'd5, 8'h01); x_pull = 1'b1;
    wait_irq(st);
    chk("R8 ignored mismatch", {st[6], st[4]}, 2'b01);
    x_pull = 1'b0;
    cmd(8'h10, st);
    chk("R5 final stop", st[7], 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule